// File: doc/BRIEF.md
# Compare-Match Timer/Counter

This block is a 16-bit up-counter with a programmable compare value. It counts ticks from one of several prescaled internal tick strobes, or it counts qualified rising edges on an external event pin. When a tick brings the count to the compare value, the block raises a one-cycle interrupt, returns the count to zero and keeps running on later ticks.

Software first writes the control word with the run bit clear to choose the source. It then writes the same word with the run bit set to start counting. While the run bit is clear, the count stays at zero. One source code takes the undivided main-clock strobe. If the low-speed flag is raised while that source is selected, only the top five compare bits take part in the match. This gives a coarse warm-up delay for the return to full-speed operation.

The external pin passes through a two-flop synchronizer and then a pulse-width filter. High or low pulses that are too short never reach the counter.

Top module: `match_timer`

## Requirements
- R1: While running, the count rises by exactly one on each tick of the selected source and holds otherwise.
- R2: When a tick would make the count equal the compare value, the count becomes 0 and `irq` is high for that one cycle. The interrupt period is therefore the compare value in ticks, and a compare value of 0 gives a period of 65536 ticks.
- R3: A write with `wr_sel`=0 loads the control word. Bits [4:2] of that word select the source: code n from 0 to 6 selects `tap_tick[n]`, and code 7 selects the filtered event pin. Taps that are not selected have no effect.
- R4: In event mode, one count is made for each rising edge where the synchronized pin stays high for at least 2 clocks after staying low for at least 2 clocks. A pulse one clock wide is ignored.
- R5: Bit 5 of the control word is the run bit. While it is 0, the count is held at 0 and no interrupt is raised.
- R6: With source code 6 and `slow_mode`=1, the match value is the compare value with its low 11 bits forced to zero. With `slow_mode`=0, all 16 bits are compared.
- R7: A write with `wr_sel`=1 loads the compare value. A change made while running applies from the next tick.
- R8: After reset, the count is 0, `irq` is 0, the block is stopped, and both the compare value and the source code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = compare value |
| wr_data | input | 16 | Write data |
| tap_tick | input | 7 | One-cycle tick strobes of the internal sources; index 6 is the undivided clock |
| ev_pin | input | 1 | Asynchronous external event input |
| slow_mode | input | 1 | Device is in the low-speed clock mode |
| count | output | 16 | Current counter value |
| irq | output | 1 | One-cycle match interrupt |

## Verification
The hardest case to reach is the coarse warm-up match. It needs the undivided-clock source, the low-speed flag and a compare value with nonzero low bits all at once, and then thousands of ticks before the match occurs. The bench holds tap 6 high for 2047 and then 2048 cycles and confirms that the interrupt comes at 0x0800 rather than at the full compare value. It then repeats the run with the flag clear. The edge filter is reached with hand-built one-cycle and two-cycle pin pulses. Random tick bursts carry noise on the taps that are not selected.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int W        = 16,
  parameter int SRC_W    = 3,
  parameter int RED_BITS = 5,
  parameter int MIN_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_sel,
  input  logic [W-1:0]              wr_data,
  input  logic [(1<<SRC_W)-2:0]     tap_tick,
  input  logic                      ev_pin,
  input  logic                      slow_mode,
  output logic [W-1:0]              count,
  output logic                      irq
);
  localparam int NTAP     = (1 << SRC_W) - 1;
  localparam int EXT_SRC  = NTAP;
  localparam int FAST_SRC = NTAP - 1;
  localparam int DW       = $clog2(MIN_W + 1);
  localparam int RUN_BIT  = 2 + SRC_W;
  localparam logic [W-1:0] HI_MASK = ~((W'(1) << (W - RED_BITS)) - W'(1));

  logic [SRC_W-1:0] src_q;
  logic             run_q;
  logic [W-1:0]     cmp_q, cnt_q;
  logic             irq_q;
  logic [1:0]       sync_q;
  logic             lvl_q;
  logic [DW-1:0]    dcnt_q;
  logic             tick;

  wire s        = sync_q[1];
  wire ev_tick  = s & ~lvl_q & (dcnt_q == DW'(MIN_W - 1));
  wire reduced  = slow_mode && (src_q == SRC_W'(FAST_SRC));
  wire [W-1:0] cmp_eff = reduced ? (cmp_q & HI_MASK) : cmp_q;
  wire [W-1:0] nxt     = cnt_q + W'(1);
  wire hit      = run_q && tick && (nxt == cmp_eff);

  always_comb begin
    if (src_q == SRC_W'(EXT_SRC)) tick = ev_tick;
    else                          tick = tap_tick[src_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      run_q <= 1'b0;
      cmp_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) cmp_q <= wr_data;
      else begin
        src_q <= wr_data[2 +: SRC_W];
        run_q <= wr_data[RUN_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
      dcnt_q <= '0;
    end else begin
      sync_q <= {sync_q[0], ev_pin};
      if (s == lvl_q) dcnt_q <= '0;
      else if (dcnt_q == DW'(MIN_W - 1)) begin
        lvl_q  <= s;
        dcnt_q <= '0;
      end else dcnt_q <= dcnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit;
      if (!run_q)    cnt_q <= '0;
      else if (tick) cnt_q <= hit ? '0 : nxt;
    end
  end

  assign count = cnt_q;
  assign irq   = irq_q;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + W'(1) || count == '0)); // R1
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> count == '0); // R2
  AST_EV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tick |-> (s && $past(s))); // R4
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (count == '0 && !irq)); // R5
  AST_RED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(reduced)) |-> ($past(count) + W'(1)) == ($past(cmp_q) & HI_MASK)); // R6
endmodule

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [6:0]  tap_tick = '0;
  logic        ev_pin = 1'b0;
  logic        slow_mode = 1'b0;
  logic [15:0] count;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  match_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tap_tick(tap_tick), .ev_pin(ev_pin), .slow_mode(slow_mode),
    .count(count), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  function automatic int exp_count(int n, int period);
    return n % period;
  endfunction

  function automatic int exp_irqs(int n, int period);
    return n / period;
  endfunction

  function automatic logic [15:0] ctrl_word(int src, bit run);
    return 16'((src << 2) | (int'(run) << 5));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int src, int n, int gap_max);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tap_tick = 7'($urandom);
      tap_tick[src] = 1'b1;
      @(negedge clk);
      tap_tick = 7'($urandom);
      tap_tick[src] = 1'b0;
      if (gap_max > 0) repeat ($urandom % (gap_max + 1)) begin
        @(negedge clk);
        tap_tick = 7'($urandom);
        tap_tick[src] = 1'b0;
      end
    end
    @(negedge clk);
    tap_tick = '0;
  endtask

  task automatic pulse(int hi, int lo);
    @(negedge clk); ev_pin = 1'b1;
    repeat (hi - 1) @(negedge clk);
    @(negedge clk); ev_pin = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, cmp, base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(count == 0, "R8 count after reset", count, 0);
    check(irq == 0, "R8 irq after reset", irq, 0);

    // R8/R5: stopped after reset, code 0 ticks do nothing
    irq_cnt = 0;
    ticks(0, 5, 0);
    check(count == 0, "R5 stopped count held", count, 0);
    check(irq_cnt == 0, "R5 stopped no irq", irq_cnt, 0);

    // R2/R1 directed: compare 5 on tap 3
    wr(0, ctrl_word(3, 0));
    wr(1, 16'd5);
    wr(0, ctrl_word(3, 1));
    irq_cnt = 0;
    ticks(3, 4, 0);
    check(count == 4, "R1 four ticks", count, 4);
    check(irq_cnt == 0, "R2 no early irq", irq_cnt, 0);
    ticks(3, 1, 0);
    check(count == 0, "R2 clear on match", count, 0);
    check(irq_cnt == 1, "R2 single irq pulse", irq_cnt, 1);

    // R7: compare change while running
    wr(1, 16'd10);
    irq_cnt = 0;
    ticks(3, 4, 1);
    wr(1, 16'd6);
    ticks(3, 2, 1);
    check(irq_cnt == 1, "R7 new compare applied", irq_cnt, 1);
    check(count == 0, "R7 cleared at new compare", count, 0);
    ticks(3, 3, 0);
    check(count == 3, "R7 counting resumes", count, 3);

    // R5: stop clears and blocks
    wr(0, ctrl_word(3, 0));
    irq_cnt = 0;
    ticks(3, 8, 0);
    check(count == 0, "R5 stop holds zero", count, 0);
    check(irq_cnt == 0, "R5 stop no irq", irq_cnt, 0);

    // R1/R2/R3 random bursts with noise on other taps
    for (int r = 0; r < 12; r++) begin
      int src;
      src = $urandom % 6;
      cmp = 1 + ($urandom % 30);
      n = $urandom % 90;
      wr(0, ctrl_word(src, 0));
      wr(1, 16'(cmp));
      wr(0, ctrl_word(src, 1));
      irq_cnt = 0;
      ticks(src, n, 3);
      check(count == exp_count(n, cmp), "R1 R3 random count", count, exp_count(n, cmp));
      check(irq_cnt == exp_irqs(n, cmp), "R2 R3 random irqs", irq_cnt, exp_irqs(n, cmp));
    end

    // R6: reduced match with code 6 in slow mode
    wr(0, ctrl_word(6, 0));
    wr(1, 16'h0BCD);
    slow_mode = 1'b1;
    wr(0, ctrl_word(6, 1));
    irq_cnt = 0;
    @(negedge clk); tap_tick = 7'h40;
    repeat (2047) @(negedge clk);
    tap_tick = '0;
    @(negedge clk);
    check(count == 2047, "R6 reduced before match", count, 2047);
    check(irq_cnt == 0, "R6 reduced no early irq", irq_cnt, 0);
    tap_tick = 7'h40;
    @(negedge clk);
    tap_tick = '0;
    @(negedge clk);
    check(irq_cnt == 1, "R6 reduced match at 0x0800", irq_cnt, 1);
    check(count == 0, "R6 reduced clear", count, 0);

    // R6: full compare when not in slow mode
    slow_mode = 1'b0;
    wr(0, ctrl_word(6, 0));
    wr(0, ctrl_word(6, 1));
    irq_cnt = 0;
    @(negedge clk); tap_tick = 7'h40;
    repeat (3020) @(negedge clk);
    tap_tick = '0;
    @(negedge clk);
    check(count == 3020 && irq_cnt == 0, "R6 full compare pending", count, 3020);
    tap_tick = 7'h40;
    @(negedge clk);
    tap_tick = '0;
    @(negedge clk);
    check(irq_cnt == 1 && count == 0, "R6 full compare match", irq_cnt, 1);

    // R4: event mode, compare 3
    wr(0, ctrl_word(7, 0));
    wr(1, 16'd3);
    wr(0, ctrl_word(7, 1));
    irq_cnt = 0;
    repeat (4) @(negedge clk);
    pulse(3, 4);
    pulse(2, 2);
    repeat (6) @(negedge clk);
    check(count == 2, "R4 wide pulses counted", count, 2);
    pulse(1, 5);
    repeat (6) @(negedge clk);
    check(count == 2, "R4 narrow pulse ignored", count, 2);
    // high, one-clock low gap, high: a single event
    @(negedge clk); ev_pin = 1'b1;
    repeat (4) @(negedge clk);
    ev_pin = 1'b0;
    @(negedge clk); ev_pin = 1'b1;
    repeat (4) @(negedge clk);
    ev_pin = 1'b0;
    repeat (8) @(negedge clk);
    check(count == 0 && irq_cnt == 1, "R4 short low gap ignored, match", count, 0);
    tap_tick = 7'h7F;
    repeat (5) @(negedge clk);
    tap_tick = '0;
    @(negedge clk);
    check(count == 0, "R3 taps ignored in event mode", count, 0);
    base = irq_cnt;
    for (int k = 0; k < 7; k++) pulse(2 + ($urandom % 3), 2 + ($urandom % 3));
    repeat (6) @(negedge clk);
    check(count == exp_count(7, 3), "R4 random event count", count, exp_count(7, 3));
    check(irq_cnt - base == exp_irqs(7, 3), "R4 random event irqs", irq_cnt - base, exp_irqs(7, 3));

    finish_run();
  end
endmodule